// File: doc/BRIEF.md
# Nonvolatile Memory Command Sequencer

This block supervises the three-step sequence that software uses to start an operation on a nonvolatile array. First, a word write to the array space latches a target address. Next, a write to the command register supplies an operation code. Finally, a status-register write with the launch bit at 1 hands the command to the array engine. Every step is checked as it arrives. A misplaced write raises a sticky access-error flag, and a write aimed at protected storage raises a sticky protection-violation flag. Either flag aborts the sequence in progress and locks the sequencer until software writes 1 to that flag's bit.

The array operation itself is stood in for by a counter. It runs for `OP_CYCLES` cycles after launch. One further command may be launched while an operation runs. It waits in a single pending slot, and the launch-empty flag stays low until the engine takes it. Entering stop with work active aborts both commands. Wait entry lets them finish. The completion interrupt is the done flag gated by an enable bit held in the configuration register.

Register accesses are single-cycle strobes with no back-pressure: a write takes effect at the clock edge where its strobe is high. A read returns its value on `rd_data` one cycle later, and that value holds until the next read.

Top module: `nvm_cmd_seq`

## Requirements
- R1: A word write in the empty stage, then an accepted command, then a status write (select 0) with bit 7 set launches the operation. `cmd_done` is low from the cycle after the launch edge for exactly `OP_CYCLES` cycles and then returns high. `launch_empty` stays high when the engine was idle.
- R2: A command write (select 1) with no latched word, or a second command write after one was accepted, sets `acc_err`. A word write while a sequence is already in progress, or while the pending slot is full, also sets `acc_err`.
- R3: Only the codes 0x05 (verify), 0x20 (program word), 0x40 (erase sector) and 0x41 (erase all) are accepted. Any other code sets `acc_err`.
- R4: Once a command has been accepted, a write to the configuration register (select 2) or to the spare register (select 3) sets `acc_err`. A configuration write still updates bit 0, the completion-interrupt enable.
- R5: A status write with bit 7 at 0 while a sequence is in progress sets `acc_err`.
- R6: With `secure_on` and `src_untrusted` both high, any code other than 0x41 sets `acc_err`. Code 0x41 is still allowed.
- R7: Register reads never set either error flag.
- R8: With `prot_en` high, `prot_err` is set in two cases. The first is program or sector erase at an address in the inclusive range `prot_lo`..`prot_hi`. The second is erase-all under any enabled protection. Verify is never refused on protection grounds.
- R9: Any error aborts the sequence. While either flag is set, word writes, command writes and launches are ignored, and the latched command keeps its value.
- R10: A status write clears `acc_err` through bit 4 and `prot_err` through bit 5 when that bit is 1. A 0 in either bit leaves that flag as it was.
- R11: Stop entry while the engine is running or holding a pending command clears both. `cmd_done` and `launch_empty` go high and `acc_err` is set. Stop entry while idle has no effect.
- R12: A launch made while the engine runs is held pending, with `launch_empty` low, and starts when the current operation ends. `wait_req` does not disturb either command.
- R13: A read returns one of the following, according to the select. Select 0 gives status: bit 7 launch_empty, bit 6 cmd_done, bit 5 prot_err, bit 4 acc_err, other bits 0. Select 1 gives the last accepted code. Select 2 gives the enable in bit 0. Select 3 gives 0. `done_irq` equals `cmd_done` AND the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 command, 2 configuration, 3 spare |
| reg_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data |
| arr_wr | input | 1 | Array word write strobe |
| arr_addr | input | ADDR_W | Array word address |
| prot_en | input | 1 | Protection enabled |
| prot_lo | input | ADDR_W | Lowest protected address |
| prot_hi | input | ADDR_W | Highest protected address |
| secure_on | input | 1 | Security enabled |
| src_untrusted | input | 1 | Access comes from a non-secure region or the debug port |
| stop_req | input | 1 | Stop-mode entry |
| wait_req | input | 1 | Wait-mode entry |
| launch_empty | output | 1 | Command buffer free (no pending command) |
| cmd_done | output | 1 | No operation running or pending |
| acc_err | output | 1 | Sticky access error |
| prot_err | output | 1 | Sticky protection violation |
| done_irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach is a stop entry while one operation runs and a second sits in the pending slot. Reaching it takes two complete, error-free sequences inside one operation window, after which stop must clear both commands at once. The bench shortens `OP_CYCLES` and issues the second sequence back to back with the first, so the pending slot fills before the stop strobe arrives. The same back-to-back stimulus, with wait held high, also shows the pending command starting in the cycle the first one ends.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [1:0] {ST_EMPTY, ST_WORD, ST_CMD} seq_st_e;
  typedef enum logic [1:0] {CHK_OK, CHK_ACC, CHK_PV} chk_e;

  localparam logic [1:0] SEL_STAT  = 2'd0;
  localparam logic [1:0] SEL_CMD   = 2'd1;
  localparam logic [1:0] SEL_CFG   = 2'd2;

  localparam logic [7:0] OP_VERIFY = 8'h05;
  localparam logic [7:0] OP_PROG   = 8'h20;
  localparam logic [7:0] OP_SECT   = 8'h40;
  localparam logic [7:0] OP_MASS   = 8'h41;

  localparam int B_LAUNCH = 7;
  localparam int B_PVIOL  = 5;
  localparam int B_ACCERR = 4;
endpackage

// File: rtl/nvm_cmd_check.sv
module nvm_cmd_check
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [7:0]        code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prot_lo,
  input  logic [ADDR_W-1:0] prot_hi,
  input  logic              prot_en,
  input  logic              secure_on,
  input  logic              src_untrusted,
  output chk_e              verdict
);
  logic known, in_range, touches;

  always_comb begin
    known    = (code == OP_VERIFY) || (code == OP_PROG) ||
               (code == OP_SECT)   || (code == OP_MASS);
    in_range = prot_en && (addr >= prot_lo) && (addr <= prot_hi);
    touches  = (code == OP_PROG) || (code == OP_SECT);
    if (!known)                                        verdict = CHK_ACC;
    else if (secure_on && src_untrusted && code != OP_MASS) verdict = CHK_ACC;
    else if (code == OP_MASS && prot_en)               verdict = CHK_PV;
    else if (touches && in_range)                      verdict = CHK_PV;
    else                                               verdict = CHK_OK;
  end
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int OP_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic pend
);
  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_CYCLES - 1);

  logic             run_q, pend_q, finishing;
  logic [CNT_W-1:0] cnt_q;

  assign finishing = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (finishing) begin
        if (pend_q) begin
          cnt_q  <= LAST;
          pend_q <= 1'b0;
        end else begin
          run_q <= 1'b0;
        end
      end else if (run_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (start) begin
        if (!run_q || (finishing && !pend_q)) begin
          run_q <= 1'b1;
          cnt_q <= LAST;
        end else begin
          pend_q <= 1'b1;
        end
      end
    end
  end

  assign busy = run_q;
  assign pend = pend_q;

  AST_PEND_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> run_q); // R12
  AST_NO_START_ON_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pend_q); // R12
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OP_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        rd_data,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              prot_en,
  input  logic [ADDR_W-1:0] prot_lo,
  input  logic [ADDR_W-1:0] prot_hi,
  input  logic              secure_on,
  input  logic              src_untrusted,
  input  logic              stop_req,
  input  logic              wait_req,
  output logic              launch_empty,
  output logic              cmd_done,
  output logic              acc_err,
  output logic              prot_err,
  output logic              done_irq
);
  seq_st_e           st_q, st_n;
  logic [7:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              acc_q, pv_q, irq_en_q;
  logic [7:0]        rd_q;
  logic              busy, pend, active, lock, abort;
  logic              wr_stat, wr_cmd, wr_other;
  logic              set_acc, set_pv, start, latch_addr, latch_cmd;
  chk_e              verdict;

  nvm_cmd_check #(.ADDR_W(ADDR_W)) u_check (
    .code(reg_wdata), .addr(addr_q), .prot_lo(prot_lo), .prot_hi(prot_hi),
    .prot_en(prot_en), .secure_on(secure_on), .src_untrusted(src_untrusted),
    .verdict(verdict)
  );

  nvm_op_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .busy(busy), .pend(pend)
  );

  assign active   = busy || pend;
  assign lock     = acc_q || pv_q;
  assign abort    = stop_req && active;
  assign wr_stat  = reg_wr && (reg_sel == SEL_STAT);
  assign wr_cmd   = reg_wr && (reg_sel == SEL_CMD);
  assign wr_other = reg_wr && (reg_sel[1] == 1'b1);

  always_comb begin
    set_acc    = 1'b0;
    set_pv     = 1'b0;
    start      = 1'b0;
    latch_addr = 1'b0;
    latch_cmd  = 1'b0;
    st_n       = st_q;
    if (!abort && !lock) begin
      if (arr_wr) begin
        if (st_q == ST_EMPTY && !pend) begin
          latch_addr = 1'b1;
          st_n       = ST_WORD;
        end else begin
          set_acc = 1'b1;
        end
      end else if (wr_cmd) begin
        if (st_q != ST_WORD) set_acc = 1'b1;
        else begin
          case (verdict)
            CHK_ACC: set_acc = 1'b1;
            CHK_PV:  set_pv  = 1'b1;
            default: begin
              latch_cmd = 1'b1;
              st_n      = ST_CMD;
            end
          endcase
        end
      end else if (wr_stat) begin
        if (st_q != ST_EMPTY && !reg_wdata[B_LAUNCH]) set_acc = 1'b1;
        else if (st_q == ST_CMD) begin
          start = 1'b1;
          st_n  = ST_EMPTY;
        end
      end else if (wr_other && st_q == ST_CMD) begin
        set_acc = 1'b1;
      end
      if (set_acc || set_pv) st_n = ST_EMPTY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_EMPTY;
      cmd_q    <= '0;
      addr_q   <= '0;
      acc_q    <= 1'b0;
      pv_q     <= 1'b0;
      irq_en_q <= 1'b0;
    end else if (abort) begin
      st_q  <= ST_EMPTY;
      acc_q <= 1'b1;
    end else begin
      st_q  <= st_n;
      acc_q <= set_acc || (acc_q && !(wr_stat && reg_wdata[B_ACCERR]));
      pv_q  <= set_pv  || (pv_q  && !(wr_stat && reg_wdata[B_PVIOL]));
      if (latch_addr) addr_q <= arr_addr;
      if (latch_cmd)  cmd_q  <= reg_wdata;
      if (reg_wr && reg_sel == SEL_CFG) irq_en_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else if (reg_rd) begin
      case (reg_sel)
        2'd0:    rd_q <= {!pend, !active, pv_q, acc_q, 4'b0000};
        2'd1:    rd_q <= cmd_q;
        2'd2:    rd_q <= {7'b0000000, irq_en_q};
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data      = rd_q;
  assign launch_empty = !pend;
  assign cmd_done     = !active;
  assign acc_err      = acc_q;
  assign prot_err     = pv_q;
  assign done_irq     = cmd_done && irq_en_q;

  AST_LAUNCH_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !cmd_done); // R1
  AST_LOCK_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !start); // R9
  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && active) |=> (cmd_done && acc_err && launch_empty)); // R11
  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !(wr_stat && reg_wdata[B_ACCERR])) |=> acc_q); // R10
  AST_PV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !(wr_stat && reg_wdata[B_PVIOL])) |=> pv_q); // R10
  AST_READ_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_q && !pv_q && !reg_wr && !arr_wr && !stop_req) |=> (!acc_q && !pv_q)); // R7
  AST_WAIT_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !stop_req && busy && !reg_wr && !arr_wr && !acc_q) |=> (!acc_q && (busy || cmd_done))); // R12
endmodule

// File: tb/test_nvm_cmd_seq.sv
module test_nvm_cmd_seq;
  localparam int AW = 16;
  localparam int OP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, arr_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [AW-1:0] arr_addr = 0, prot_lo = 16'h8000, prot_hi = 16'h8FFF;
  logic prot_en = 0, secure_on = 0, src_untrusted = 0, stop_req = 0, wait_req = 0;
  logic [7:0] rd_data;
  logic launch_empty, cmd_done, acc_err, prot_err, done_irq;

  nvm_cmd_seq #(.ADDR_W(AW), .OP_CYCLES(OP)) i_nvm_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .arr_wr(arr_wr), .arr_addr(arr_addr),
    .prot_en(prot_en), .prot_lo(prot_lo), .prot_hi(prot_hi), .secure_on(secure_on),
    .src_untrusted(src_untrusted), .stop_req(stop_req), .wait_req(wait_req),
    .launch_empty(launch_empty), .cmd_done(cmd_done), .acc_err(acc_err),
    .prot_err(prot_err), .done_irq(done_irq)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference state
  int m_stage, m_rem;
  bit m_pend, m_acc, m_pv, m_irq, p_pend, m_active, m_lock, m_go, m_err;
  logic [7:0] m_cmd, m_rd;
  logic [AW-1:0] m_addr;

  function automatic int judge(input logic [7:0] c, input logic [AW-1:0] a);
    if (!(c == 8'h05 || c == 8'h20 || c == 8'h40 || c == 8'h41)) return 1;
    if (secure_on && src_untrusted && c != 8'h41) return 1;
    if (c == 8'h41 && prot_en) return 2;
    if ((c == 8'h20 || c == 8'h40) && prot_en && a >= prot_lo && a <= prot_hi) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_rem = 0; m_pend = 0; m_acc = 0; m_pv = 0; m_irq = 0;
      m_cmd = 0; m_rd = 0; m_addr = 0;
    end else begin
      p_pend = m_pend;
      m_active = (m_rem > 0) || m_pend;
      m_lock = m_acc || m_pv;
      m_go = 0; m_err = 0;
      if (reg_rd) begin
        if (reg_sel == 0) m_rd = {!m_pend, !m_active, m_pv, m_acc, 4'b0};
        else if (reg_sel == 1) m_rd = m_cmd;
        else if (reg_sel == 2) m_rd = {7'b0, m_irq};
        else m_rd = 0;
      end
      if (stop_req && m_active) begin
        m_rem = 0; m_pend = 0; m_acc = 1; m_stage = 0;
      end else begin
        if (m_rem > 0) begin
          m_rem--;
          if (m_rem == 0 && m_pend) begin m_rem = OP; m_pend = 0; end
        end
        if (!m_lock) begin
          if (arr_wr) begin
            if (m_stage == 0 && !p_pend) begin m_stage = 1; m_addr = arr_addr; end
            else m_err = 1;
          end else if (reg_wr && reg_sel == 1) begin
            if (m_stage != 1) m_err = 1;
            else begin
              case (judge(reg_wdata, m_addr))
                1: m_err = 1;
                2: begin m_pv = 1; m_stage = 0; end
                default: begin m_cmd = reg_wdata; m_stage = 2; end
              endcase
            end
          end else if (reg_wr && reg_sel == 0) begin
            if (m_stage != 0 && !reg_wdata[7]) m_err = 1;
            else if (m_stage == 2) begin m_go = 1; m_stage = 0; end
          end else if (reg_wr && reg_sel >= 2 && m_stage == 2) m_err = 1;
        end
        if (m_err) begin m_acc = 1; m_stage = 0; end
        if (reg_wr && reg_sel == 0 && m_lock) begin
          if (reg_wdata[4]) m_acc = 0;
          if (reg_wdata[5]) m_pv = 0;
        end
        if (reg_wr && reg_sel == 2) m_irq = reg_wdata[0];
        if (m_go) begin
          if (m_rem == 0) m_rem = OP; else m_pend = 1;
        end
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({cur_req, " launch_empty"}, launch_empty, !m_pend);
      chk({cur_req, " cmd_done"}, cmd_done, (m_rem == 0) && !m_pend);
      chk({cur_req, " acc_err"}, acc_err, m_acc);
      chk({cur_req, " prot_err"}, prot_err, m_pv);
      chk({cur_req, " done_irq"}, done_irq, (m_rem == 0) && !m_pend && m_irq);
      chk({cur_req, " rd_data"}, rd_data, m_rd);
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic put_word(input logic [AW-1:0] a);
    arr_addr = a; arr_wr = 1; step(); arr_wr = 0;
  endtask
  task automatic put_reg(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
  endtask
  task automatic rd_reg(input logic [1:0] s);
    reg_sel = s; reg_rd = 1; step(); reg_rd = 0;
  endtask
  task automatic run_seq(input logic [AW-1:0] a, input logic [7:0] c);
    put_word(a); put_reg(2'd1, c); put_reg(2'd0, 8'h80);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    cur_req = "R13";
    chk("R13 reset done", cmd_done, 1); chk("R13 reset empty", launch_empty, 1);
    chk("R10 reset flags", {acc_err, prot_err}, 0);

    cur_req = "R1";
    run_seq(16'h0100, 8'h20);
    chk("R1 done low after launch", cmd_done, 0);
    chk("R1 empty stays high", launch_empty, 1);
    idle(OP - 1); chk("R1 still running", cmd_done, 0);
    idle(1);      chk("R1 done after window", cmd_done, 1);

    cur_req = "R12";
    wait_req = 1;
    run_seq(16'h0200, 8'h40);
    run_seq(16'h0300, 8'h05);
    chk("R12 pending empty low", launch_empty, 0);
    idle(2 * OP);
    chk("R12 both finished", cmd_done, 1);
    chk("R12 no error under wait", acc_err, 0);
    wait_req = 0;

    cur_req = "R2";
    put_word(16'h0010); put_reg(2'd1, 8'h20); put_reg(2'd1, 8'h20);
    chk("R2 second command", acc_err, 1);
    put_reg(2'd0, 8'h00); chk("R10 zero keeps flag", acc_err, 1);
    put_reg(2'd0, 8'h10); chk("R10 one clears flag", acc_err, 0);
    put_reg(2'd1, 8'h20); chk("R2 command without word", acc_err, 1);
    put_reg(2'd0, 8'h10);

    cur_req = "R3";
    put_word(16'h0010); put_reg(2'd1, 8'h33);
    chk("R3 bad code", acc_err, 1);
    put_reg(2'd0, 8'h10);

    cur_req = "R4";
    put_word(16'h0010); put_reg(2'd1, 8'h20); put_reg(2'd2, 8'h01);
    chk("R4 config after command", acc_err, 1);
    put_reg(2'd0, 8'h10);
    rd_reg(2'd2); chk("R4 enable updated", rd_data, 8'h01);
    cur_req = "R13";
    chk("R13 irq when idle", done_irq, 1);

    cur_req = "R5";
    put_word(16'h0010); put_reg(2'd1, 8'h20); put_reg(2'd0, 8'h00);
    chk("R5 launch bit zero", acc_err, 1);
    put_reg(2'd0, 8'h10);

    cur_req = "R6";
    secure_on = 1; src_untrusted = 1;
    put_word(16'h0010); put_reg(2'd1, 8'h20);
    chk("R6 untrusted program", acc_err, 1);
    put_reg(2'd0, 8'h10);
    run_seq(16'h0000, 8'h41);
    chk("R6 erase-all allowed", {acc_err, cmd_done}, 2'b00);
    idle(OP);
    secure_on = 0; src_untrusted = 0;

    cur_req = "R7";
    put_word(16'h0020); rd_reg(2'd0); put_reg(2'd1, 8'h05);
    rd_reg(2'd1); rd_reg(2'd2); rd_reg(2'd3);
    put_reg(2'd0, 8'h80); rd_reg(2'd0);
    chk("R7 reads leave no error", {acc_err, prot_err}, 0);
    chk("R13 status during run", rd_data, 8'h80);
    rd_reg(2'd1); chk("R13 command readback", rd_data, 8'h05);
    idle(OP);

    cur_req = "R8";
    prot_en = 1;
    put_word(16'h8010); put_reg(2'd1, 8'h20);
    chk("R8 protected program", prot_err, 1);
    put_reg(2'd0, 8'h20); chk("R10 clear pviol", prot_err, 0);
    put_word(16'h8FFF); put_reg(2'd1, 8'h40);
    chk("R8 top of range", prot_err, 1);
    put_reg(2'd0, 8'h20);
    run_seq(16'h9000, 8'h20);
    chk("R8 just outside", {prot_err, cmd_done}, 2'b00);
    idle(OP);
    put_word(16'h0000); put_reg(2'd1, 8'h41);
    chk("R8 erase-all protected", prot_err, 1);
    put_reg(2'd0, 8'h20);
    run_seq(16'h8010, 8'h05);
    chk("R8 verify allowed", {prot_err, cmd_done}, 2'b00);
    idle(OP);
    prot_en = 0;

    cur_req = "R9";
    put_reg(2'd1, 8'h40);
    run_seq(16'h0040, 8'h40);
    chk("R9 locked no launch", cmd_done, 1);
    rd_reg(2'd1); chk("R9 command kept", rd_data, 8'h05);
    put_reg(2'd0, 8'h10);
    run_seq(16'h0040, 8'h40);
    chk("R9 runs after clear", cmd_done, 0);
    idle(OP);

    cur_req = "R11";
    run_seq(16'h0100, 8'h20);
    run_seq(16'h0200, 8'h20);
    chk("R11 pending before stop", launch_empty, 0);
    stop_req = 1; step(); stop_req = 0;
    chk("R11 stop aborts", {cmd_done, acc_err, launch_empty}, 3'b111);
    put_reg(2'd0, 8'h10);
    stop_req = 1; step(); stop_req = 0;
    chk("R11 stop idle harmless", acc_err, 0);
    idle(3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule